// File: doc/BRIEF.md
# Two-Level Page Translation Walker

This block turns a 32-bit linear address into a physical address. Each walk reads two 32-bit entries from memory: a first-level entry found through a directory frame number supplied with the request, and then a second-level entry found through the frame named by the first one. Pages are 4 KB. The physical address is the 20-bit frame from the second-level entry joined to the 12-bit offset of the linear address. Linear address bits 31:22 index the directory and bits 21:12 index the table. Inside an entry, bit 0 is present, bit 1 is read/write, bit 2 is user/supervisor, bit 5 is accessed, bit 6 is dirty, and bits 31:12 hold the frame.

The walker checks the present bit at both levels. It applies a protection check that depends on privilege: levels 0 to 2 may always read and write. Level 3 needs user/supervisor set, and for a write it also needs read/write set. At table level the check uses the AND of both entries' bits, so the stricter setting wins. A walk that succeeds sets the accessed bit in both entries. On a write it also sets the dirty bit in the table entry. The walker stores an entry back to memory only when one of its bits changes, and these stores finish before the response is given.

The controller moves through these states. IDLE goes to READ_PDE when a request is accepted. READ_PDE goes to CHECK_PDE when the read data returns. CHECK_PDE goes to FAULT or to READ_PTE. READ_PTE goes to CHECK_PTE. CHECK_PTE goes to FAULT, to WRITEBACK, or to DONE when nothing changed. WRITEBACK goes to DONE once the last store is accepted. DONE and FAULT each return to IDLE after one cycle.

Top module: `pg_walker`

## Requirements
- R1: A successful response gives `rsp_paddr` = {second-level entry bits 31:12, linear address bits 11:0}.
- R2: The first-level entry is read at {dir_frame, laddr[31:22], 2'b00}. The second-level entry is read at {first-level entry bits 31:12, laddr[21:12], 2'b00}.
- R3: A first-level entry with bit 0 clear ends the walk with a not-present fault at directory level, and no second-level read is made.
- R4: A second-level entry with bit 0 clear ends the walk with a not-present fault at table level.
- R5: At privilege 0, 1 or 2, present entries always translate, whatever their bits 1 and 2 hold.
- R6: At privilege 3, an access needs bit 2 set, and a write also needs bit 1 set. At table level these bits are the AND of both entries.
- R7: A protection failure that the first-level entry alone causes is reported at directory level. Any other protection failure is reported at table level.
- R8: A successful walk leaves bit 5 set in both entries. It sets bit 6 of the second-level entry on writes only, and it never changes bit 6 of the first-level entry.
- R9: An entry is written back only if its value changes, and a faulting walk writes nothing.
- R10: A fault response has `rsp_fault`=1 and `rsp_paddr`=0. `flt_prot` is 0 for not present and 1 for protection. `flt_tbl` is 0 for directory level and 1 for table level. `flt_wr` is 1 for a write access.
- R11: After reset `req_ready`=1 with no memory request. `req_ready` is high only in IDLE. `rsp_valid` is a one-cycle pulse. A memory request holds its address and direction until it is accepted.
- R12: All write-backs are accepted before `rsp_valid` rises, and `mem_valid` is low while `rsp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_laddr | input | 32 | Linear address |
| req_write | input | 1 | 1 = write access |
| req_cpl | input | 2 | Privilege level of the access |
| dir_frame | input | 20 | Frame number of the directory |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Response is a fault |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| flt_prot | output | 1 | Fault kind: 1 = protection, 0 = not present |
| flt_tbl | output | 1 | Fault level: 1 = table, 0 = directory |
| flt_wr | output | 1 | Access type of the faulting walk |
| mem_valid | output | 1 | Memory request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_write | output | 1 | 1 = store, 0 = load |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to store |
| mem_rvalid | input | 1 | Load data valid |
| mem_rdata | input | 32 | Load data |

## Verification
The bench builds the walker with its default widths: a 10-bit directory index, a 10-bit table index, a 12-bit offset and 32-bit entries. With these widths, every combination of present, read/write and user/supervisor at both levels can be crossed with each preset pattern of the accessed and dirty bits, all four privilege levels and both access types. That gives 4096 walks. Each walk runs against a memory that refuses one request cycle in three. The expected fault code, physical address, stored entries and number of stores are all derived arithmetically from the entry bits.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_PDE,
        ST_CHECK_PDE,
        ST_READ_PTE,
        ST_CHECK_PTE,
        ST_WRITEBACK,
        ST_DONE,
        ST_FAULT
    } walk_state_t;

    // entry bit positions
    localparam int BIT_P  = 0;
    localparam int BIT_RW = 1;
    localparam int BIT_US = 2;
    localparam int BIT_A  = 5;
    localparam int BIT_D  = 6;

    typedef struct packed {
        logic prot;  // 1 = protection, 0 = not present
        logic tbl;   // 1 = table level, 0 = directory level
        logic wr;    // access type
    } fault_t;

endpackage

// File: rtl/pgw_perm.sv
module pgw_perm (
    input  logic [1:0] cpl,
    input  logic       wr,
    input  logic       us,
    input  logic       rw,
    output logic       ok
);
    logic user_lvl;

    always_comb begin
        user_lvl = (cpl == 2'd3);
        if (!user_lvl) begin
            ok = 1'b1;
        end else begin
            ok = us && (!wr || rw);
        end
    end
endmodule

// File: rtl/pgw_upd.sv
module pgw_upd #(
    parameter int ENT_W = 32
) (
    input  logic [ENT_W-1:0] entry,
    input  logic             set_d,
    output logic [ENT_W-1:0] entry_new,
    output logic             changed
);
    always_comb begin
        entry_new = entry;
        entry_new[pgw_pkg::BIT_A] = 1'b1;
        if (set_d) begin
            entry_new[pgw_pkg::BIT_D] = 1'b1;
        end
        changed = (entry_new != entry);
    end
endmodule

// File: rtl/pg_walker.sv
module pg_walker #(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    parameter int ENT_W = 32,
    localparam int LA_W = 2 * IDX_W + OFF_W,
    localparam int FRAME_W = ENT_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [LA_W-1:0]    req_laddr,
    input  logic               req_write,
    input  logic [1:0]         req_cpl,
    input  logic [FRAME_W-1:0] dir_frame,
    output logic               rsp_valid,
    output logic               rsp_fault,
    output logic [LA_W-1:0]    rsp_paddr,
    output logic               flt_prot,
    output logic               flt_tbl,
    output logic               flt_wr,
    output logic               mem_valid,
    input  logic               mem_ready,
    output logic               mem_write,
    output logic [LA_W-1:0]    mem_addr,
    output logic [ENT_W-1:0]   mem_wdata,
    input  logic               mem_rvalid,
    input  logic [ENT_W-1:0]   mem_rdata
);
    import pgw_pkg::*;

    localparam int ALIGN_W = LA_W - FRAME_W - IDX_W;

    walk_state_t state_q, state_d;

    logic [LA_W-1:0]    lin_q;
    logic               wr_q;
    logic [1:0]         cpl_q;
    logic [FRAME_W-1:0] base_q;
    logic [ENT_W-1:0]   pde_q, pte_q;
    logic               rd_wait;
    logic               wb_pde, wb_pte;
    fault_t             flt_q;

    logic [IDX_W-1:0]   dir_idx, tbl_idx;
    logic [OFF_W-1:0]   pg_off;
    logic [LA_W-1:0]    pde_addr, pte_addr;
    logic               pde_ok, both_ok;
    logic               us_and, rw_and;
    logic [ENT_W-1:0]   pde_new, pte_new;
    logic               pde_chg, pte_chg;
    logic               rd_done, wb_last;

    assign dir_idx  = lin_q[LA_W-1 -: IDX_W];
    assign tbl_idx  = lin_q[OFF_W +: IDX_W];
    assign pg_off   = lin_q[OFF_W-1:0];
    assign pde_addr = {base_q, dir_idx, {ALIGN_W{1'b0}}};
    assign pte_addr = {pde_q[ENT_W-1 -: FRAME_W], tbl_idx, {ALIGN_W{1'b0}}};
    assign us_and   = pde_q[BIT_US] & pte_q[BIT_US];
    assign rw_and   = pde_q[BIT_RW] & pte_q[BIT_RW];
    assign rd_done  = rd_wait && mem_rvalid;
    assign wb_last  = mem_ready && !(wb_pde && wb_pte);

    pgw_perm u_perm_dir (
        .cpl (cpl_q),
        .wr  (wr_q),
        .us  (pde_q[BIT_US]),
        .rw  (pde_q[BIT_RW]),
        .ok  (pde_ok)
    );

    pgw_perm u_perm_all (
        .cpl (cpl_q),
        .wr  (wr_q),
        .us  (us_and),
        .rw  (rw_and),
        .ok  (both_ok)
    );

    pgw_upd #(.ENT_W(ENT_W)) u_upd_dir (
        .entry     (pde_q),
        .set_d     (1'b0),
        .entry_new (pde_new),
        .changed   (pde_chg)
    );

    pgw_upd #(.ENT_W(ENT_W)) u_upd_tbl (
        .entry     (pte_q),
        .set_d     (wr_q),
        .entry_new (pte_new),
        .changed   (pte_chg)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = ST_READ_PDE;
            ST_READ_PDE:  if (rd_done) state_d = ST_CHECK_PDE;
            ST_CHECK_PDE: begin
                if (!pde_q[BIT_P] || !pde_ok) state_d = ST_FAULT;
                else state_d = ST_READ_PTE;
            end
            ST_READ_PTE:  if (rd_done) state_d = ST_CHECK_PTE;
            ST_CHECK_PTE: begin
                if (!pte_q[BIT_P] || !both_ok) state_d = ST_FAULT;
                else if (pde_chg || pte_chg) state_d = ST_WRITEBACK;
                else state_d = ST_DONE;
            end
            ST_WRITEBACK: if (wb_last) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            ST_FAULT:     state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_q   <= '0;
            wr_q    <= 1'b0;
            cpl_q   <= 2'd0;
            base_q  <= '0;
            pde_q   <= '0;
            pte_q   <= '0;
            rd_wait <= 1'b0;
            wb_pde  <= 1'b0;
            wb_pte  <= 1'b0;
            flt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        lin_q  <= req_laddr;
                        wr_q   <= req_write;
                        cpl_q  <= req_cpl;
                        base_q <= dir_frame;
                    end
                    rd_wait <= 1'b0;
                    wb_pde  <= 1'b0;
                    wb_pte  <= 1'b0;
                end
                ST_READ_PDE, ST_READ_PTE: begin
                    if (mem_valid && mem_ready) rd_wait <= 1'b1;
                    if (rd_done) begin
                        rd_wait <= 1'b0;
                        if (state_q == ST_READ_PDE) pde_q <= mem_rdata;
                        else                        pte_q <= mem_rdata;
                    end
                end
                ST_CHECK_PDE: begin
                    flt_q.prot <= pde_q[BIT_P];
                    flt_q.tbl  <= 1'b0;
                    flt_q.wr   <= wr_q;
                end
                ST_CHECK_PTE: begin
                    flt_q.prot <= pte_q[BIT_P];
                    flt_q.tbl  <= 1'b1;
                    flt_q.wr   <= wr_q;
                    if (pte_q[BIT_P] && both_ok) begin
                        wb_pde <= pde_chg;
                        wb_pte <= pte_chg;
                        pde_q  <= pde_new;
                        pte_q  <= pte_new;
                    end
                end
                ST_WRITEBACK: begin
                    if (mem_ready) begin
                        if (wb_pde) wb_pde <= 1'b0;
                        else        wb_pte <= 1'b0;
                    end
                end
                ST_DONE, ST_FAULT: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_fault = 1'b0;
        rsp_paddr = '0;
        flt_prot  = 1'b0;
        flt_tbl   = 1'b0;
        flt_wr    = 1'b0;
        mem_valid = 1'b0;
        mem_write = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state_q)
            ST_IDLE:      req_ready = 1'b1;
            ST_READ_PDE: begin
                mem_valid = !rd_wait;
                mem_addr  = pde_addr;
            end
            ST_READ_PTE: begin
                mem_valid = !rd_wait;
                mem_addr  = pte_addr;
            end
            ST_WRITEBACK: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_addr  = wb_pde ? pde_addr : pte_addr;
                mem_wdata = wb_pde ? pde_q : pte_q;
            end
            ST_DONE: begin
                rsp_valid = 1'b1;
                rsp_paddr = {pte_q[ENT_W-1 -: FRAME_W], pg_off};
            end
            ST_FAULT: begin
                rsp_valid = 1'b1;
                rsp_fault = 1'b1;
                flt_prot  = flt_q.prot;
                flt_tbl   = flt_q.tbl;
                flt_wr    = flt_q.wr;
            end
            ST_CHECK_PDE, ST_CHECK_PTE: ;
        endcase
    end
endmodule

// File: rtl/pgw_chk.sv
module pgw_chk #(
    parameter int LA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_fault,
    input logic [LA_W-1:0] rsp_paddr,
    input logic            mem_valid,
    input logic            mem_ready,
    input logic            mem_write,
    input logic [LA_W-1:0] mem_addr,
    input logic            wd_p,
    input logic            wd_a
);
    // R11
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write));

    // R11
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready && !rsp_valid);

    // R8
    wb_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && mem_write |-> wd_p && wd_a);

    // R10
    fault_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> rsp_paddr == '0);

    // R9
    fault_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> !$past(mem_write));

    // R12
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !mem_valid && !req_ready);
endmodule

bind pg_walker pgw_chk #(.LA_W(LA_W)) i_pgw_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_paddr (rsp_paddr),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_write (mem_write),
    .mem_addr  (mem_addr),
    .wd_p      (mem_wdata[0]),
    .wd_a      (mem_wdata[5])
);

// File: tb/test_pg_walker.sv
module test_pg_walker;
    localparam int CLK_PERIOD = 10;
    localparam int WALK_LIMIT = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_laddr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_cpl = 2'd0;
    logic [19:0] dir_frame = '0;
    logic        rsp_valid, rsp_fault, flt_prot, flt_tbl, flt_wr;
    logic [31:0] rsp_paddr;
    logic        mem_valid, mem_write;
    logic        mem_ready = 1'b0;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int vectors = 0;
    int errors  = 0;
    int wr_cnt  = 0;
    int rdy_cnt = 0;
    bit hung    = 1'b0;

    logic [31:0] mem [logic [31:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    pg_walker i_pg_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
        .req_write(req_write), .req_cpl(req_cpl), .dir_frame(dir_frame),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .flt_prot(flt_prot), .flt_tbl(flt_tbl), .flt_wr(flt_wr),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // memory refuses one cycle in three
    always @(negedge clk) begin
        mem_ready <= (rdy_cnt % 3) != 2;
        rdy_cnt   <= rdy_cnt + 1;
    end

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (rst_n && mem_valid && mem_ready) begin
            if (mem_write) begin
                mem[mem_addr] = mem_wdata;
                wr_cnt = wr_cnt + 1;
            end else begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic walk(input int n, input logic [2:0] pde_fl, input logic [2:0] pte_fl,
                        input logic [2:0] pre, input logic [1:0] cpl, input logic wr);
        logic [19:0] base, ptf, pgf;
        logic [9:0]  di, ti;
        logic [11:0] off;
        logic [31:0] pa_de, pa_te, pde, pte, pde_x, pte_x;
        logic        f, fprot, ftbl, us_a, rw_a;
        int          wexp, w0, guard;
        base = 20'h00100;
        ptf  = 20'h00200 + 20'(n[7:0]);
        pgf  = 20'hA0000 ^ 20'(n);
        di   = 10'(n * 13);
        ti   = 10'(n * 7 + 3);
        off  = 12'(n * 37);
        pa_de = {base, di, 2'b00};
        pa_te = {ptf, ti, 2'b00};
        pde = {ptf, 5'b0, 1'b0, pre[0], 2'b0, pde_fl};
        pte = {pgf, 5'b0, pre[2], pre[1], 2'b0, pte_fl};
        mem.delete();
        mem[pa_de] = pde;
        mem[pa_te] = pte;
        // expected outcome (R3 R4 R5 R6 R7)
        us_a = pde_fl[2] & pte_fl[2];
        rw_a = pde_fl[1] & pte_fl[1];
        f = 1'b1; fprot = 1'b0; ftbl = 1'b0;
        pde_x = pde; pte_x = pte; wexp = 0;
        if (!pde_fl[0]) begin
            fprot = 1'b0; ftbl = 1'b0;
        end else if (cpl == 2'd3 && (!pde_fl[2] || (wr && !pde_fl[1]))) begin
            fprot = 1'b1; ftbl = 1'b0;
        end else if (!pte_fl[0]) begin
            fprot = 1'b0; ftbl = 1'b1;
        end else if (cpl == 2'd3 && (!us_a || (wr && !rw_a))) begin
            fprot = 1'b1; ftbl = 1'b1;
        end else begin
            f = 1'b0;
            pde_x = pde | 32'h20;
            pte_x = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
            wexp = (pde_x != pde ? 1 : 0) + (pte_x != pte ? 1 : 0);
        end
        @(negedge clk);
        w0 = wr_cnt;
        req_valid = 1'b1;
        req_laddr = {di, ti, off};
        req_write = wr;
        req_cpl   = cpl;
        dir_frame = base;
        @(posedge clk);
        guard = 0;
        do begin
            @(negedge clk);
            req_valid = 1'b0;
            guard++;
        end while (!rsp_valid && guard < WALK_LIMIT);
        if (!rsp_valid) begin
            hung = 1'b1;
            vectors++;
            errors++;
            $display("FAIL R11: walk %0d no response, actual %h expected %h", n, 1'b0, 1'b1);
            return;
        end
        // R1 R2 R3 R4 R5 R6 R7 R10
        chk("R1/R2/R3/R4/R5/R6/R7/R10 response",
            {27'b0, rsp_fault, flt_prot, flt_tbl, flt_wr, 1'b0, rsp_paddr},
            {27'b0, f, f & fprot, f & ftbl, f & wr, 1'b0, (f ? 32'h0 : {pgf, off})});
        // R8 R9 R12: stores already visible at response time
        chk("R8/R12 first-level entry", {32'b0, mem[pa_de]}, {32'b0, pde_x});
        chk("R8/R12 second-level entry", {32'b0, mem[pa_te]}, {32'b0, pte_x});
        chk("R9 store count", 64'(wr_cnt - w0), 64'(wexp));
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 reset req_ready", {63'b0, req_ready}, 64'd1);
        chk("R11 reset rsp_valid", {63'b0, rsp_valid}, 64'd0);
        chk("R11 reset mem_valid", {63'b0, mem_valid}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle after reset", {62'b0, req_ready, mem_valid}, 64'd2);
        n = 0;
        for (int a = 0; a < 8 && !hung; a++)
            for (int b = 0; b < 8 && !hung; b++)
                for (int p = 0; p < 8 && !hung; p++)
                    for (int c = 0; c < 4 && !hung; c++)
                        for (int w = 0; w < 2 && !hung; w++) begin
                            walk(n, 3'(a), 3'(b), 3'(p), 2'(c), w[0]);
                            n++;
                        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule